// File: doc/BRIEF.md
# Boot Area Selector

This block makes the start-up decision between the protected bootloader area and the unprotected application area of an on-chip flash. A pulse from the reset sequencer starts a scan. The block reads the control field, which is the last `FIELD_BYTES` bytes of the flash address space. It reads one byte per cycle, starting at the highest address and moving down. It adds up the set bits of every byte as the bytes return. From the parity of the final total it picks the area the core will start in.

The decision depends only on parity, so clearing any one bit of the field flips it. Firmware can therefore hand control between bootloader and application by clearing single bits. A clear that is cut off by power loss leaves the bit either set or cleared, and both states give a legal decision. The core is held in reset until the scan finishes. The chosen area then stays fixed until the next reset.

Top module: `bsel_top`

## Requirements
- R1: During and right after reset, `done_o` is 0, `rd_en_o` is 0, `sel_prot_o` is 0 and `core_hold_o` is 1.
- R2: A `start_i` pulse seen while idle produces exactly `FIELD_BYTES` (default 16) read requests on consecutive cycles. No other read request is ever made.
- R3: The first read address is the highest flash address (all ones, `2**ADDR_W-1`). Each following request is one lower, so the last one is `2**ADDR_W-FIELD_BYTES`.
- R4: The number of set bits across all returned field bytes is summed. An even total drives `sel_prot_o` to 1 (protected bootloader area). An odd total drives it to 0 (application area).
- R5: `done_o` rises `FIELD_BYTES + RD_LAT` clock edges after the edge that samples `start_i`. `rd_data_i` is taken `RD_LAT` cycles (default 1) after its request.
- R6: Once `done_o` is 1, it and `sel_prot_o` stay constant until the next reset. Later `start_i` pulses cause no reads.
- R7: A `start_i` pulse that arrives during a scan has no effect. The scan still issues exactly `FIELD_BYTES` reads and finishes at the R5 time.
- R8: `core_hold_o` is 1 exactly while `done_o` is 0.
- R9: Two fields that differ in a single bit give opposite values of `sel_prot_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Scan start pulse from the reset sequencer |
| rd_en_o | output | 1 | Flash byte read request |
| rd_addr_o | output | ADDR_W | Flash byte address |
| rd_data_i | input | DATA_W | Flash read data, valid RD_LAT cycles after the request |
| done_o | output | 1 | Decision made and latched |
| sel_prot_o | output | 1 | 1 = start in protected area, 0 = start in application area |
| core_hold_o | output | 1 | Holds the core in reset until the decision is made |

## Verification
On every cycle the assertions check four things: the length of each read burst, the top-down address order, that `done_o` and the selection stay fixed once set, and that the hold output is the inverse of done. Only the bench scenarios can show that the parity rule picks the right area. They do this with known field contents: all ones, all zeros, single-bit fields and pairs that differ in one bit. The scenarios also measure the exact completion latency, and they show that a start pulse arriving mid-scan or after completion is ignored.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_DONE = 2'd2
   } bsel_state_e;
endpackage

// File: rtl/bsel_addr_gen.sv
module bsel_addr_gen #(
   parameter int ADDR_W      = 15,
   parameter int FIELD_BYTES = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              go_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o
);
   localparam int IDX_W = $clog2(FIELD_BYTES);
   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(FIELD_BYTES - 1);

   logic             active_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         idx_q    <= '0;
      end else if (!active_q) begin
         if (go_i) begin
            active_q <= 1'b1;
            idx_q    <= '0;
         end
      end else if (idx_q == LAST_IDX) begin
         active_q <= 1'b0;
      end else begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign rd_en_o   = active_q;
   assign rd_addr_o = TOP_ADDR - ADDR_W'(idx_q);
endmodule

// File: rtl/bsel_rd_pipe.sv
module bsel_rd_pipe #(
   parameter int RD_LAT = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   output logic vld_o
);
   generate
      if (RD_LAT == 1) begin : g_single
         logic vld_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) vld_q <= 1'b0;
            else         vld_q <= req_i;
         end
         assign vld_o = vld_q;
      end else begin : g_chain
         logic [RD_LAT-1:0] sh_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sh_q <= '0;
            else         sh_q <= {sh_q[RD_LAT-2:0], req_i};
         end
         assign vld_o = sh_q[RD_LAT-1];
      end
   endgenerate
endmodule

// File: rtl/bsel_popcount.sv
module bsel_popcount #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CNT_W-1:0]  ones_o
);
   logic [CNT_W-1:0] part [DATA_W+1];

   assign part[0] = '0;
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign part[b+1] = part[b] + CNT_W'(data_i[b]);
      end
   endgenerate

   assign ones_o = part[DATA_W];
endmodule

// File: rtl/bsel_top.sv
module bsel_top
   import bsel_pkg::*;
#(
   parameter int ADDR_W       = 15,
   parameter int DATA_W       = 8,
   parameter int FIELD_BYTES  = 16,
   parameter int RD_LAT       = 1,
   parameter bit EVEN_IS_PROT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              done_o,
   output logic              sel_prot_o,
   output logic              core_hold_o
);
   localparam int TOTAL_BITS = FIELD_BYTES * DATA_W;
   localparam int CNT_W      = $clog2(TOTAL_BITS + 1);
   localparam int IDX_W      = $clog2(FIELD_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FIELD_BYTES - 1);

   generate
      if (FIELD_BYTES < 2) begin : g_bad_field
         $error("FIELD_BYTES must be at least 2");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W too small for the control field");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("RD_LAT must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
   endgenerate

   bsel_state_e      state_q;
   logic             go;
   logic             rx_vld;
   logic [IDX_W-1:0] rx_idx_q;
   logic [CNT_W-1:0] acc_q;
   logic [CNT_W-1:0] byte_ones;
   logic [CNT_W-1:0] total;
   logic             odd_total;
   logic             pick_prot;
   logic             done_q;
   logic             sel_q;

   assign go = (state_q == ST_IDLE) && start_i;

   bsel_addr_gen #(
      .ADDR_W      (ADDR_W),
      .FIELD_BYTES (FIELD_BYTES)
   ) addr_gen_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .go_i      (go),
      .rd_en_o   (rd_en_o),
      .rd_addr_o (rd_addr_o)
   );

   bsel_rd_pipe #(
      .RD_LAT (RD_LAT)
   ) rd_pipe_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (rd_en_o),
      .vld_o  (rx_vld)
   );

   bsel_popcount #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) popcount_i (
      .data_i (rd_data_i),
      .ones_o (byte_ones)
   );

   assign total     = acc_q + byte_ones;
   assign odd_total = total[0];

   generate
      if (EVEN_IS_PROT) begin : g_even_prot
         assign pick_prot = ~odd_total;
      end else begin : g_odd_prot
         assign pick_prot = odd_total;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         rx_idx_q <= '0;
         acc_q    <= '0;
         done_q   <= 1'b0;
         sel_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (go) begin
                  state_q  <= ST_SCAN;
                  rx_idx_q <= '0;
                  acc_q    <= '0;
               end
            end
            ST_SCAN: begin
               if (rx_vld) begin
                  acc_q    <= total;
                  rx_idx_q <= rx_idx_q + 1'b1;
                  if (rx_idx_q == LAST_IDX) begin
                     state_q <= ST_DONE;
                     done_q  <= 1'b1;
                     sel_q   <= pick_prot;
                  end
               end
            end
            ST_DONE: begin
               state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o      = done_q;
   assign sel_prot_o  = sel_q;
   assign core_hold_o = ~done_q;
endmodule

// File: rtl/bsel_checker.sv
module bsel_checker #(
   parameter int ADDR_W      = 15,
   parameter int FIELD_BYTES = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              rd_en_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              done_o,
   input logic              sel_prot_o,
   input logic              core_hold_o
);
   localparam int RUN_W = $clog2(FIELD_BYTES + 1) + 1;
   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      run_q <= '0;
      else if (rd_en_o) run_q <= run_q + 1'b1;
      else              run_q <= '0;
   end

   AST_BURST_NOT_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_o |-> run_q < RUN_W'(FIELD_BYTES)); // R2
   AST_BURST_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rd_en_o) |-> run_q == RUN_W'(FIELD_BYTES)); // R2
   AST_FIRST_ADDR_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rd_en_o) |-> rd_addr_o == TOP_ADDR); // R3
   AST_ADDR_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_o && $past(rd_en_o)) |-> rd_addr_o == $past(rd_addr_o) - ADDR_W'(1)); // R3
   AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> done_o); // R6
   AST_SEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> $stable(sel_prot_o)); // R6
   AST_NO_READ_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !rd_en_o); // R6
   AST_SEL_ZERO_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> !sel_prot_o); // R1
   AST_HOLD_MATCHES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_hold_o != done_o); // R8
endmodule

bind bsel_top bsel_checker #(
   .ADDR_W      (ADDR_W),
   .FIELD_BYTES (FIELD_BYTES)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .rd_en_o     (rd_en_o),
   .rd_addr_o   (rd_addr_o),
   .done_o      (done_o),
   .sel_prot_o  (sel_prot_o),
   .core_hold_o (core_hold_o)
);

// File: tb/bsel_top_tb_top.sv
module bsel_top_tb_top;
   localparam int ADDR_W = 15;
   localparam int DATA_W = 8;
   localparam int NB     = 16;
   localparam int RD_LAT = 1;
   localparam int TOP    = (1 << ADDR_W) - 1;
   localparam int EXP_LAT = NB + RD_LAT + 1;

   typedef struct {
      logic sel;
      int   lat;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              rd_en;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data = '0;
   logic              done;
   logic              sel;
   logic              hold;

   int errors = 0;
   int checks = 0;

   logic [DATA_W-1:0] fld [NB];
   exp_t              exp_q [$];
   logic [ADDR_W-1:0] addr_q [$];
   int                post_rd = 0;

   always #5 clk = ~clk;

   bsel_top #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .FIELD_BYTES (NB), .RD_LAT (RD_LAT)
   ) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .start_i (start),
      .rd_en_o (rd_en), .rd_addr_o (rd_addr), .rd_data_i (rd_data),
      .done_o (done), .sel_prot_o (sel), .core_hold_o (hold)
   );

   function automatic logic [DATA_W-1:0] flash_byte(input logic [ADDR_W-1:0] a);
      int idx;
      idx = TOP - int'(a);
      if (idx >= 0 && idx < NB) return fld[idx];
      return 8'h5A;
   endfunction

   always @(posedge clk) if (rd_en) rd_data <= flash_byte(rd_addr);

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: pops expected items and compares them as results appear
   initial begin
      bit armed = 0;
      bit prev_done = 0;
      int cnt = 0;
      int rd_cnt = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            armed = 0; prev_done = 0; cnt = 0; rd_cnt = 0; post_rd = 0;
         end else begin
            if (armed) cnt++;
            if (!armed && !done && start) begin
               armed = 1; cnt = 0;
            end
            if (rd_en) begin
               rd_cnt++;
               if (done) post_rd++;
               if (addr_q.size() == 0) begin
                  check("R2", 1, 0, "unexpected read request");
               end else begin
                  logic [ADDR_W-1:0] ea;
                  ea = addr_q.pop_front();
                  check("R3", int'(rd_addr), int'(ea), "read address");
               end
            end
            if (done && !prev_done) begin
               if (exp_q.size() == 0) begin
                  check("R5", 1, 0, "done without expected item");
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  check("R4", int'(sel), int'(e.sel), "area selection");
                  check("R5", cnt, e.lat, "completion latency");
                  check("R2", rd_cnt, NB, "read count");
                  check("R8", int'(hold), 0, "hold released at done");
               end
            end
            prev_done = done;
         end
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic run_scan(input logic [NB*DATA_W-1:0] f, input bit mid_start,
                           output logic got_sel);
      exp_t e;
      logic first_sel;
      do_reset();
      for (int i = 0; i < NB; i++) fld[i] = f[DATA_W*i +: DATA_W];
      e.sel = ($countones(f) % 2 == 0);
      e.lat = EXP_LAT;
      exp_q.push_back(e);
      for (int i = 0; i < NB; i++) addr_q.push_back(ADDR_W'(TOP - i));
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      if (mid_start) begin
         repeat (5) @(posedge clk);
         #1 start = 1'b1;               // R7: pulse inside scan
         @(posedge clk); #1 start = 1'b0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
      first_sel = sel;
      got_sel = sel;
      // R6: late start pulse must cause no reads and no change
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      repeat (20) @(negedge clk);
      check("R6", post_rd, 0, "reads after done");
      check("R6", int'(done), 1, "done held");
      check("R6", int'(sel), int'(first_sel), "selection held");
      check("R2", addr_q.size(), 0, "missing read requests");
      addr_q.delete();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R5 watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic s0, s1;
      logic [NB*DATA_W-1:0] p;
      // R1 / R8 reset state
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1", int'(done), 0, "done in reset");
      check("R1", int'(rd_en), 0, "read in reset");
      check("R1", int'(sel), 0, "selection in reset");
      check("R8", int'(hold), 1, "hold in reset");
      #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", int'(rd_en), 0, "idle without start");
      check("R8", int'(hold), 1, "hold before scan");

      run_scan('1, 0, s0);                      // R4: 128 ones, even
      check("R4", int'(s0), 1, "all ones -> protected");
      run_scan('0, 0, s0);                      // R4: zero, even
      check("R4", int'(s0), 1, "all zeros -> protected");
      p = '1; p[77] = 1'b0;
      run_scan(p, 0, s0);                       // R4: 127, odd
      check("R4", int'(s0), 0, "one bit cleared -> application");
      p = '0; p[3] = 1'b1;
      run_scan(p, 0, s0);
      check("R4", int'(s0), 0, "single set bit -> application");

      // R9 pairs differing in one bit
      p = 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
      run_scan(p, 0, s0);
      p[37] = ~p[37];
      run_scan(p, 0, s1);
      check("R9", int'(s0 ^ s1), 1, "single-bit flip changes choice");
      p = 128'hDEAD_BEEF_0000_FFFF_1357_9BDF_2468_ACE0;
      run_scan(p, 0, s0);
      p[127] = ~p[127];
      run_scan(p, 0, s1);
      check("R9", int'(s0 ^ s1), 1, "top bit flip changes choice");

      // R7 start during scan is ignored
      run_scan(128'hA5A5_0F0F_3C3C_FFFF_0001_8000_7E7E_1111, 1, s0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule